// File: doc/BRIEF.md
# Fixed-Length Serial Block Transfer Engine

This block copies a fixed block of 64 bytes between a byte-wide main memory and a 64-byte local controller RAM. Software loads a memory address, then pulses one of two start strobes: a fetch (main memory into the local RAM) or a flush (local RAM out to main memory). The engine clears the low three address bits, so every block starts on an 8-byte boundary. It moves one byte per cycle and raises a completion interrupt at the end.

Main-memory byte addresses are swizzled by XOR 3 so that bytes land in big-endian lane order. The address is treated as a signed quantity. A request whose address is above the memory size is rejected outright. Byte positions that fall below zero are handled differently per direction: a fetch fills them with zero, and a flush skips them. The work of the device that consumes the controller RAM is not modelled here. It is represented only by a one-cycle notify pulse. That pulse comes after the data on a fetch and before the data on a flush.

Top module: `blk64_dma`

## Requirements
- R1: An accepted request moves exactly 64 bytes, one per cycle. `busy` is high from the cycle after the start strobe until the completion cycle inclusive: 66 cycles for a fetch and 67 cycles for a flush. No memory or RAM access happens while `busy` is low.
- R2: The block base address is the loaded address with bits [2:0] cleared. Byte i of the block sits at base + i and maps to local RAM index i.
- R3: If the loaded address, read as a signed ADDR_W-bit value, is greater than MEM_SIZE, a start is dropped. There is no busy, no access, no notify and no interrupt. An address equal to MEM_SIZE is accepted.
- R4: Every main-memory read or write for position p uses the address p XOR 3.
- R5: On a fetch, a byte whose position is negative (bit ADDR_W-1 set) is not read from memory and is written to the local RAM as 0x00.
- R6: On a flush, a byte whose position is negative issues no memory write. Every memory write therefore has bit ADDR_W-1 clear.
- R7: Completion pulses `irqPulse` for exactly one cycle. In the following cycle the sticky `irqFlag` is set. After reset both are low.
- R8: On a fetch, `notify` pulses once, in the completion cycle, after the last RAM write. On a flush, `notify` pulses once, in the cycle after the start strobe, two cycles before the first memory write.
- R9: A `statWr` pulse clears `irqFlag` on the next cycle, unless a completion occurs in the same cycle.
- R10: Start strobes are ignored while `busy` is high. If both strobes arrive together, the fetch is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrWr | input | 1 | Load the address register |
| addrWrData | input | ADDR_W | Address value to load |
| startFetch | input | 1 | Start a memory-to-RAM transfer |
| startFlush | input | 1 | Start a RAM-to-memory transfer |
| statWr | input | 1 | Status write; clears the sticky interrupt flag |
| memAddr | output | ADDR_W | Main-memory byte address (swizzled) |
| memRdEn | output | 1 | Memory read; data is returned one cycle later |
| memRdData | input | 8 | Memory read data |
| memWrEn | output | 1 | Memory byte write |
| memWrData | output | 8 | Memory write data |
| ramAddr | output | 6 | Local RAM byte index |
| ramRdEn | output | 1 | RAM read; data is returned one cycle later |
| ramRdData | input | 8 | RAM read data |
| ramWrEn | output | 1 | RAM byte write |
| ramWrData | output | 8 | RAM write data |
| busy | output | 1 | Transfer in progress |
| irqFlag | output | 1 | Sticky completion flag |
| irqPulse | output | 1 | One-cycle completion pulse to the shared interrupt |
| notify | output | 1 | One-cycle pulse that hands the RAM to its consumer |

## Verification
The assertions check, on every cycle, the properties that hold for all cycles. No access occurs while idle. Memory writes never target a negative position. The notify pulse never coincides with a data write. The flag rises only after a completion pulse, and a status write clears it. The bench scenarios are needed for the properties that depend on data and sequence: the XOR-3 byte placement, the 8-byte alignment, zero-fill versus skip across the zero boundary, the exact busy length, the notify cycle relative to the first and last data beat, and the bounds edge at exactly MEM_SIZE.

// File: rtl/blk64_pkg.sv
package blk64_pkg;
  localparam int BLK_BYTES = 64;
  localparam int IDX_W = $clog2(BLK_BYTES);

  typedef struct packed {
    logic             capture;  // latch aligned base address
    logic             issue;    // read stage active this cycle
    logic             dirFlush; // 1: RAM to memory, 0: memory to RAM
    logic [IDX_W-1:0] idx;      // byte index of the read stage
  } ctlStrb_t;
endpackage

// File: rtl/blk64_ctrl.sv
module blk64_ctrl
  import blk64_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     startFetch,
  input  logic     startFlush,
  input  logic     addrOk,
  input  logic     statWr,
  output ctlStrb_t ctl,
  output logic     busy,
  output logic     irqPulse,
  output logic     irqFlag,
  output logic     notify
);
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_RUN, S_DRAIN, S_DONE} state_t;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_BYTES - 1);

  state_t           state;
  logic [IDX_W-1:0] cnt;
  logic             dirFlush;
  logic             accept;

  assign accept = (state == S_IDLE) && (startFetch || startFlush) && addrOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      dirFlush <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (accept) begin
          dirFlush <= !startFetch;
          cnt      <= '0;
          state    <= startFetch ? S_RUN : S_PRE;
        end
        S_PRE: state <= S_RUN;
        S_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_IDX) state <= S_DRAIN;
        end
        S_DRAIN: state <= S_DONE;
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         irqFlag <= 1'b0;
    else if (irqPulse) irqFlag <= 1'b1;
    else if (statWr)   irqFlag <= 1'b0;
  end

  always_comb begin
    ctl.capture  = accept;
    ctl.issue    = (state == S_RUN);
    ctl.dirFlush = dirFlush;
    ctl.idx      = cnt;
  end

  assign busy     = (state != S_IDLE);
  assign irqPulse = (state == S_DONE);
  assign notify   = (state == S_PRE) || ((state == S_DONE) && !dirFlush);
endmodule

// File: rtl/blk64_dpath.sv
module blk64_dpath
  import blk64_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MEM_SIZE = ADDR_W'(32'h0080_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          ctl,
  input  logic              addrWr,
  input  logic [ADDR_W-1:0] addrWrData,
  output logic              addrOk,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [7:0]        memRdData,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic [IDX_W-1:0]  ramAddr,
  output logic              ramRdEn,
  input  logic [7:0]        ramRdData,
  output logic              ramWrEn,
  output logic [7:0]        ramWrData
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(7);
  localparam logic [ADDR_W-1:0] LANE_SWZ   = ADDR_W'(3);

  logic [ADDR_W-1:0] addrReg, base, pos, wrPos;
  logic              posNeg, wrNeg, wrValid;
  logic [IDX_W-1:0]  wrIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      base    <= '0;
    end else begin
      if (addrWr)      addrReg <= addrWrData;
      if (ctl.capture) base    <= addrReg & ALIGN_MASK;
    end
  end

  assign addrOk = !($signed(addrReg) > $signed(MEM_SIZE));
  assign pos    = base + ADDR_W'(ctl.idx);
  assign posNeg = pos[ADDR_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrValid <= 1'b0;
      wrIdx   <= '0;
      wrPos   <= '0;
      wrNeg   <= 1'b0;
    end else begin
      wrValid <= ctl.issue;
      wrIdx   <= ctl.idx;
      wrPos   <= pos;
      wrNeg   <= posNeg;
    end
  end

  always_comb begin
    memRdEn   = ctl.issue && !ctl.dirFlush && !posNeg;
    ramRdEn   = ctl.issue && ctl.dirFlush;
    memAddr   = (ctl.dirFlush ? wrPos : pos) ^ LANE_SWZ;
    ramAddr   = ctl.dirFlush ? ctl.idx : wrIdx;
    ramWrEn   = wrValid && !ctl.dirFlush;
    ramWrData = wrNeg ? 8'h00 : memRdData;
    memWrEn   = wrValid && ctl.dirFlush && !wrNeg;
    memWrData = ramRdData;
  end
endmodule

// File: rtl/blk64_dma.sv
module blk64_dma
  import blk64_pkg::*;
#(
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] MEM_SIZE = ADDR_W'(32'h0080_0000)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrWr,
  input  logic [ADDR_W-1:0] addrWrData,
  input  logic              startFetch,
  input  logic              startFlush,
  input  logic              statWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRdEn,
  input  logic [7:0]        memRdData,
  output logic              memWrEn,
  output logic [7:0]        memWrData,
  output logic [IDX_W-1:0]  ramAddr,
  output logic              ramRdEn,
  input  logic [7:0]        ramRdData,
  output logic              ramWrEn,
  output logic [7:0]        ramWrData,
  output logic              busy,
  output logic              irqFlag,
  output logic              irqPulse,
  output logic              notify
);
  ctlStrb_t ctl;
  logic     addrOk;

  blk64_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startFetch(startFetch), .startFlush(startFlush),
    .addrOk(addrOk), .statWr(statWr), .ctl(ctl), .busy(busy),
    .irqPulse(irqPulse), .irqFlag(irqFlag), .notify(notify)
  );

  blk64_dpath #(.ADDR_W(ADDR_W), .MEM_SIZE(MEM_SIZE)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addrWr(addrWr), .addrWrData(addrWrData),
    .addrOk(addrOk), .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .ramAddr(ramAddr), .ramRdEn(ramRdEn),
    .ramRdData(ramRdData), .ramWrEn(ramWrEn), .ramWrData(ramWrData)
  );
endmodule

// File: rtl/blk64_chk.sv
module blk64_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic              ramRdEn,
  input logic              ramWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              notify,
  input logic              irqPulse,
  input logic              irqFlag,
  input logic              statWr
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(memRdEn || memWrEn || ramRdEn || ramWrEn));

  // R6
  no_neg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !memAddr[ADDR_W-1]);

  // R8
  notify_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    notify |-> !(memWrEn || ramWrEn));

  // R7
  irq_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> busy);

  // R7
  flag_after_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> irqFlag);

  // R7
  flag_rise_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqFlag) |-> $past(irqPulse));

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && !irqPulse) |=> !irqFlag);
endmodule

bind blk64_dma blk64_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .memRdEn(memRdEn), .memWrEn(memWrEn),
  .ramRdEn(ramRdEn), .ramWrEn(ramWrEn), .memAddr(memAddr), .notify(notify),
  .irqPulse(irqPulse), .irqFlag(irqFlag), .statWr(statWr)
);

// File: tb/tb_blk64_dma.sv
module tb_blk64_dma;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam logic [31:0] MSIZE = 32'd256;
  localparam int TBMEM = 512;

  logic clk = 1'b0, rstN = 1'b0;
  logic addrWr = 0, startFetch = 0, startFlush = 0, statWr = 0;
  logic [31:0] addrWrData = '0;
  logic [31:0] memAddr;
  logic memRdEn, memWrEn, ramRdEn, ramWrEn, busy, irqFlag, irqPulse, notify;
  logic [7:0] memRdData, memWrData, ramRdData, ramWrData;
  logic [5:0] ramAddr;

  logic [7:0] mem [TBMEM];
  logic [7:0] ram [64];
  logic [7:0] snap [TBMEM];

  int total = 0, bad = 0, cyc = 0;
  int busyCnt, irqCnt, irqCyc, notCnt, notCyc, memWrCnt, firstMemWr, oobCnt;
  int ramWrCnt, lastRamWr, memRdCnt;

  blk64_dma #(.ADDR_W(ADDR_W), .MEM_SIZE(MSIZE)) dut (
    .clk(clk), .rstN(rstN), .addrWr(addrWr), .addrWrData(addrWrData),
    .startFetch(startFetch), .startFlush(startFlush), .statWr(statWr),
    .memAddr(memAddr), .memRdEn(memRdEn), .memRdData(memRdData),
    .memWrEn(memWrEn), .memWrData(memWrData), .ramAddr(ramAddr),
    .ramRdEn(ramRdEn), .ramRdData(ramRdData), .ramWrEn(ramWrEn),
    .ramWrData(ramWrData), .busy(busy), .irqFlag(irqFlag),
    .irqPulse(irqPulse), .notify(notify)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (memWrEn && memAddr < TBMEM) mem[memAddr[8:0]] <= memWrData;
    if (memRdEn) memRdData <= mem[memAddr[8:0]];
    if (ramWrEn) ram[ramAddr] <= ramWrData;
    if (ramRdEn) ramRdData <= ram[ramAddr];
  end

  always @(negedge clk) begin
    if (busy) busyCnt++;
    if (irqPulse) begin irqCnt++; irqCyc = cyc; end
    if (notify) begin notCnt++; notCyc = cyc; end
    if (memRdEn) memRdCnt++;
    if (memWrEn) begin
      memWrCnt++;
      if (firstMemWr < 0) firstMemWr = cyc;
      if (memAddr >= TBMEM) oobCnt++;
    end
    if (ramWrEn) begin ramWrCnt++; lastRamWr = cyc; end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearStats();
    busyCnt = 0; irqCnt = 0; irqCyc = -1; notCnt = 0; notCyc = -1;
    memWrCnt = 0; firstMemWr = -1; oobCnt = 0; ramWrCnt = 0; lastRamWr = -1;
    memRdCnt = 0;
  endtask

  task automatic fillMem();
    for (int k = 0; k < TBMEM; k++) mem[k] = 8'((k * 7 + 1) & 255);
  endtask

  task automatic fillRam(input int seed);
    for (int k = 0; k < 64; k++) ram[k] = 8'((seed + k * 3) | 1);
  endtask

  task automatic loadAddr(input logic [31:0] a);
    @(negedge clk); addrWr = 1; addrWrData = a;
    @(negedge clk); addrWr = 0;
  endtask

  // returns the cycle number in which the strobe was driven
  task automatic kick(input bit f, input bit w, output int n);
    clearStats();
    @(negedge clk); startFetch = f; startFlush = w; n = cyc;
    @(negedge clk); startFetch = 0; startFlush = 0;
    repeat (75) @(negedge clk);
  endtask

  task automatic tReset();
    chk("R1 busy after reset", busy, 0);
    chk("R7 irqFlag after reset", irqFlag, 0);
    chk("R7 irqPulse after reset", irqPulse, 0);
  endtask

  task automatic tFetchBasic();
    int n, errs = 0;
    fillMem(); fillRam(5);
    loadAddr(32'h45);
    kick(1, 0, n);
    for (int i = 0; i < 64; i++) if (ram[i] !== mem[(32'h40 + i) ^ 3]) errs++;
    chk("R2 R4 fetch data mismatches", errs, 0);
    chk("R1 fetch busy cycles", busyCnt, 66);
    chk("R1 fetch ram writes", ramWrCnt, 64);
    chk("R7 fetch irq pulses", irqCnt, 1);
    chk("R7 fetch irq cycle", irqCyc, n + 66);
    chk("R8 fetch notify cycle", notCyc, n + 66);
    chk("R8 fetch notify count", notCnt, 1);
    chk("R8 fetch last ram write", lastRamWr, n + 65);
    chk("R7 flag set", irqFlag, 1);
  endtask

  task automatic tStatClear();
    @(negedge clk); statWr = 1;
    @(negedge clk); statWr = 0;
    chk("R9 flag cleared", irqFlag, 0);
  endtask

  task automatic tFlushBasic();
    int n, errs = 0;
    fillMem(); fillRam(40);
    loadAddr(32'h83);
    kick(0, 1, n);
    for (int i = 0; i < 64; i++) if (mem[(32'h80 + i) ^ 3] !== ram[i]) errs++;
    chk("R2 R4 flush data mismatches", errs, 0);
    chk("R1 flush mem writes", memWrCnt, 64);
    chk("R1 flush busy cycles", busyCnt, 67);
    chk("R8 flush notify cycle", notCyc, n + 1);
    chk("R8 flush first mem write", firstMemWr, n + 3);
    chk("R7 flush irq cycle", irqCyc, n + 67);
    @(negedge clk); statWr = 1; @(negedge clk); statWr = 0;
  endtask

  task automatic tFetchNeg();
    int n, errs = 0;
    fillMem(); fillRam(9);
    loadAddr(32'hFFFF_FFE4);
    kick(1, 0, n);
    for (int i = 0; i < 32; i++) if (ram[i] !== 8'h00) errs++;
    chk("R5 negative bytes zero", errs, 0);
    errs = 0;
    for (int j = 0; j < 32; j++) if (ram[32 + j] !== mem[j ^ 3]) errs++;
    chk("R5 positive half data", errs, 0);
    chk("R5 memory reads issued", memRdCnt, 32);
    @(negedge clk); statWr = 1; @(negedge clk); statWr = 0;
  endtask

  task automatic tFlushNeg();
    int n, errs = 0;
    fillMem(); fillRam(77);
    for (int k = 0; k < TBMEM; k++) snap[k] = mem[k];
    loadAddr(32'hFFFF_FFE0);
    kick(0, 1, n);
    chk("R6 mem write count", memWrCnt, 32);
    chk("R6 out of range writes", oobCnt, 0);
    for (int j = 0; j < 32; j++) if (mem[j ^ 3] !== ram[32 + j]) errs++;
    for (int k = 32; k < TBMEM; k++) if (mem[k] !== snap[k]) errs++;
    chk("R6 memory image", errs, 0);
    @(negedge clk); statWr = 1; @(negedge clk); statWr = 0;
  endtask

  task automatic tBounds();
    int n, errs = 0;
    fillMem(); fillRam(11);
    for (int k = 0; k < TBMEM; k++) snap[k] = mem[k];
    loadAddr(32'h108);
    kick(1, 0, n);
    chk("R3 fetch dropped busy", busyCnt, 0);
    chk("R3 fetch dropped irq", irqCnt + notCnt + irqFlag, 0);
    chk("R3 fetch dropped reads", memRdCnt + ramWrCnt, 0);
    kick(0, 1, n);
    for (int k = 0; k < TBMEM; k++) if (mem[k] !== snap[k]) errs++;
    chk("R3 flush dropped memory", errs + memWrCnt + busyCnt + notCnt, 0);
    loadAddr(32'h100);
    kick(1, 0, n);
    chk("R3 edge address accepted", busyCnt, 66);
    @(negedge clk); statWr = 1; @(negedge clk); statWr = 0;
  endtask

  task automatic tBusyIgnore();
    int n, errs = 0;
    fillMem(); fillRam(21);
    loadAddr(32'h10);
    clearStats();
    @(negedge clk); startFetch = 1; n = cyc;
    @(negedge clk); startFetch = 0;
    repeat (10) @(negedge clk);
    addrWr = 1; addrWrData = 32'h20; startFlush = 1;
    @(negedge clk); addrWr = 0; startFlush = 0;
    repeat (75) @(negedge clk);
    for (int i = 0; i < 64; i++) if (ram[i] !== mem[(32'h10 + i) ^ 3]) errs++;
    chk("R10 data of first request", errs, 0);
    chk("R10 no flush while busy", memWrCnt, 0);
    chk("R10 single completion", irqCnt, 1);
    @(negedge clk); statWr = 1; @(negedge clk); statWr = 0;
    fillRam(3);
    kick(1, 1, n);
    chk("R10 both strobes fetch ram writes", ramWrCnt, 64);
    chk("R10 both strobes no mem writes", memWrCnt, 0);
  endtask

  initial begin
    fillMem(); fillRam(0); clearStats();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tReset();
    tFetchBasic();
    tStatClear();
    tFlushBasic();
    tFetchNeg();
    tFlushNeg();
    tBounds();
    tBusyIgnore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule